// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This block resolves the two control-transfer instructions of a simple load-store processor: a conditional branch and a conditional branch that also records a return address. When a start pulse arrives it looks at the instruction word, the already-incremented program counter and two values read from the register file. One value is the jump target. The other is the value the condition is tested against. One clock later it presents its decision.

A jump target never comes from the instruction itself. It is always the contents of the target register. A 3-bit condition code in the lowest instruction bits picks one of these tests:
- never taken
- always taken
- test value is zero
- test value is nonzero
- test value's sign bit is clear
- test value's sign bit is set

The linking form writes the incremented PC to its destination register whether or not the jump is taken. Only the PC replacement depends on the condition. The surrounding fetch logic consumes the PC-load pulse, and the register file consumes the link-write pulse.

Top module: `bru_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first start pulse, `pcLoad`, `taken` and `linkWe` are all 0.
- R2: The outputs reflect a start pulse exactly one clock after the edge that samples it. `pcLoad`, `taken` and `linkWe` are single-cycle pulses and are 0 in any cycle that does not follow a sampled start.
- R3: The opcode is instruction bits [31:27]. The value 8 is the plain conditional branch and the value 9 is the linking branch. Any other opcode produces no `pcLoad`, no `taken` and no `linkWe`.
- R4: The condition code is instruction bits [2:0], and bits [11:3] have no effect. Code 0 is never taken and code 1 is always taken.
- R5: Code 2 is taken when the test value equals zero, and code 3 is taken when it is nonzero.
- R6: Code 4 is taken when bit 31 of the test value is 0, and code 5 is taken when bit 31 is 1.
- R7: Codes 6 and 7 are never taken.
- R8: When `pcLoad` is 1, `pcNew` equals the target-register value that was presented with the start pulse.
- R9: For opcode 9, `linkWe` is 1 regardless of the condition. `linkIdx` equals instruction bits [26:22], and `linkVal` equals the incremented PC presented with the start pulse. This holds even when the link register is also the target register.
- R10: For opcode 8, `linkWe` stays 0 for every condition code.
- R11: `taken` equals `pcLoad` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse; inputs are sampled on the same edge |
| instr | input | 32 | Instruction word |
| pcNext | input | 32 | Incremented program counter |
| targetVal | input | 32 | Contents of the target register |
| testVal | input | 32 | Contents of the condition register |
| pcLoad | output | 1 | Pulse: load `pcNew` into the PC |
| pcNew | output | 32 | Jump destination |
| taken | output | 1 | Pulse: the condition held |
| linkWe | output | 1 | Pulse: write `linkVal` to register `linkIdx` |
| linkIdx | output | 5 | Link destination register index |
| linkVal | output | 32 | Return address to write |

## Verification
The bench sweeps every opcode against every condition code. Each pair is tried with test values at zero, one, the largest positive value, the most negative value and all ones, with filler in bits [11:3] that changes from case to case. This catches:
- a design that inverts the zero test or reads the wrong sign bit, which jumps on the wrong values;
- a design that decodes codes 6 and 7 as aliases of lower codes, which jumps where it must not;
- a design that gates the link write by the condition, which drops return addresses on untaken linking branches;
- a design that decodes a neighbouring opcode, which loads the PC on unrelated instructions.

After every decision an idle cycle confirms that the pulses fall back to zero.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int OP_W = 5;
  localparam int CC_W = 3;
  localparam logic [OP_W-1:0] OPC_BRANCH = 5'd8;
  localparam logic [OP_W-1:0] OPC_BRLINK = 5'd9;

  typedef enum logic [CC_W-1:0] {
    CC_NEVER   = 3'd0,
    CC_ALWAYS  = 3'd1,
    CC_ZERO    = 3'd2,
    CC_NONZERO = 3'd3,
    CC_NONNEG  = 3'd4,
    CC_NEG     = 3'd5,
    CC_RSV6    = 3'd6,
    CC_RSV7    = 3'd7
  } condCode_e;

  typedef struct packed {
    logic capture;
    logic loadPc;
    logic writeLink;
  } ctrlStrb_t;
endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  condCode_e         code,
  input  logic [DATA_W-1:0] testVal,
  output logic              hit
);
  localparam int SIGN_BIT = DATA_W - 1;

  logic isZero;
  logic isNeg;

  assign isZero = (testVal == '0);
  assign isNeg  = testVal[SIGN_BIT];

  always_comb begin
    unique case (code)
      CC_ALWAYS:  hit = 1'b1;
      CC_ZERO:    hit = isZero;
      CC_NONZERO: hit = !isZero;
      CC_NONNEG:  hit = !isNeg;
      CC_NEG:     hit = isNeg;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              go,
  input  logic [OP_W-1:0]   opField,
  input  logic [CC_W-1:0]   ccField,
  input  logic [DATA_W-1:0] testVal,
  output ctrlStrb_t         strb
);
  logic isBranch;
  logic isLink;
  logic condHit;
  condCode_e code;

  assign code     = condCode_e'(ccField);
  assign isBranch = (opField == OPC_BRANCH);
  assign isLink   = (opField == OPC_BRLINK);

  bru_cond #(.DATA_W(DATA_W)) u_cond (
    .code   (code),
    .testVal(testVal),
    .hit    (condHit)
  );

  always_comb begin
    strb           = '0;
    strb.capture   = go;
    strb.loadPc    = go && (isBranch || isLink) && condHit;
    strb.writeLink = go && isLink;
  end
endmodule

// File: rtl/bru_dp.sv
module bru_dp
  import bru_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] targetVal,
  input  logic [DATA_W-1:0] pcNext,
  input  logic [REG_W-1:0]  raField,
  output logic              pcLoad,
  output logic [DATA_W-1:0] pcNew,
  output logic              taken,
  output logic              linkWe,
  output logic [REG_W-1:0]  linkIdx,
  output logic [DATA_W-1:0] linkVal
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcLoad <= 1'b0;
      taken  <= 1'b0;
      linkWe <= 1'b0;
    end else begin
      pcLoad <= strb.loadPc;
      taken  <= strb.loadPc;
      linkWe <= strb.writeLink;
    end
  end

  // link value and target both come from the values presented with go,
  // so a link into the target register cannot disturb the jump address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcNew   <= '0;
      linkIdx <= '0;
      linkVal <= '0;
    end else if (strb.capture) begin
      pcNew   <= targetVal;
      linkIdx <= raField;
      linkVal <= pcNext;
    end
  end
endmodule

// File: rtl/bru_top.sv
module bru_top
  import bru_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int REG_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               go,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  pcNext,
  input  logic [DATA_W-1:0]  targetVal,
  input  logic [DATA_W-1:0]  testVal,
  output logic               pcLoad,
  output logic [DATA_W-1:0]  pcNew,
  output logic               taken,
  output logic               linkWe,
  output logic [REG_W-1:0]   linkIdx,
  output logic [DATA_W-1:0]  linkVal
);
  localparam int OP_LSB = INSTR_W - OP_W;
  localparam int RA_LSB = OP_LSB - REG_W;

  logic [OP_W-1:0]  opField;
  logic [REG_W-1:0] raField;
  logic [CC_W-1:0]  ccField;
  logic             unusedFields;
  ctrlStrb_t        strb;

  assign opField      = instr[INSTR_W-1:OP_LSB];
  assign raField      = instr[OP_LSB-1:RA_LSB];
  assign ccField      = instr[CC_W-1:0];
  assign unusedFields = ^instr[RA_LSB-1:CC_W];

  bru_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .go     (go),
    .opField(opField),
    .ccField(ccField),
    .testVal(testVal),
    .strb   (strb)
  );

  bru_dp #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .targetVal(targetVal),
    .pcNext   (pcNext),
    .raField  (raField),
    .pcLoad   (pcLoad),
    .pcNew    (pcNew),
    .taken    (taken),
    .linkWe   (linkWe),
    .linkIdx  (linkIdx),
    .linkVal  (linkVal)
  );
endmodule

// File: rtl/bru_chk.sv
module bru_chk
  import bru_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              go,
  input logic [OP_W-1:0]   opField,
  input logic [REG_W-1:0]  raField,
  input logic [CC_W-1:0]   ccField,
  input logic [DATA_W-1:0] pcNext,
  input logic [DATA_W-1:0] targetVal,
  input logic              pcLoad,
  input logic [DATA_W-1:0] pcNew,
  input logic              taken,
  input logic              linkWe,
  input logic [REG_W-1:0]  linkIdx,
  input logic [DATA_W-1:0] linkVal
);
  logic armed;
  logic isBrOp;

  assign isBrOp = (opField == OPC_BRANCH) || (opField == OPC_BRLINK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (!pcLoad && !taken && !linkWe);
    end
  end

  a_r2_pulse_only: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(go) |-> !pcLoad && !taken && !linkWe);

  a_r3_other_ops: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(go && !isBrOp) |-> !pcLoad && !linkWe);

  a_r4_never: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(go && ccField == 3'd0) |-> !pcLoad);

  a_r7_reserved: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(go && ccField[2] && ccField[1]) |-> !pcLoad);

  a_r8_target: assert property (@(posedge clk) disable iff (!rstN)
    armed && pcLoad |-> pcNew == $past(targetVal));

  a_r9_link: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(go && opField == OPC_BRLINK)
      |-> linkWe && linkIdx == $past(raField) && linkVal == $past(pcNext));

  a_r10_no_link: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(go && opField == OPC_BRANCH) |-> !linkWe);
endmodule

bind bru_top bru_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .go       (go),
  .opField  (instr[INSTR_W-1:OP_LSB]),
  .raField  (instr[OP_LSB-1:RA_LSB]),
  .ccField  (instr[2:0]),
  .pcNext   (pcNext),
  .targetVal(targetVal),
  .pcLoad   (pcLoad),
  .pcNew    (pcNew),
  .taken    (taken),
  .linkWe   (linkWe),
  .linkIdx  (linkIdx),
  .linkVal  (linkVal)
);

// File: tb/sim_bru_top.sv
module sim_bru_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        go = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pcNext = '0;
  logic [31:0] targetVal = '0;
  logic [31:0] testVal = '0;
  logic        pcLoad;
  logic [31:0] pcNew;
  logic        taken;
  logic        linkWe;
  logic [4:0]  linkIdx;
  logic [31:0] linkVal;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bru_top u0 (
    .clk(clk), .rstN(rstN), .go(go), .instr(instr), .pcNext(pcNext),
    .targetVal(targetVal), .testVal(testVal), .pcLoad(pcLoad), .pcNew(pcNew),
    .taken(taken), .linkWe(linkWe), .linkIdx(linkIdx), .linkVal(linkVal)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit expectHit(input logic [2:0] cc, input logic [31:0] tv);
    case (cc)
      3'd1:    return 1'b1;
      3'd2:    return tv == 32'd0;
      3'd3:    return tv != 32'd0;
      3'd4:    return tv[31] == 1'b0;
      3'd5:    return tv[31] == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] pickTest(input int k);
    case (k)
      0:       return 32'h0000_0000;
      1:       return 32'h0000_0001;
      2:       return 32'h7FFF_FFFF;
      3:       return 32'h8000_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic runCase(input logic [4:0] op, input logic [2:0] cc,
                         input logic [31:0] tv, input int idx);
    logic [4:0] ra;
    logic [8:0] filler;
    logic       expLoad;
    logic       expLink;
    ra     = 5'(idx);
    filler = 9'(idx * 37 + 5);
    @(negedge clk);
    // ra and rb fields set equal: the link register is also the target register
    instr     = {op, ra, ra, 5'(idx >> 2), filler, cc};
    pcNext    = 32'h0000_4000 + 32'(idx * 4);
    targetVal = 32'h1000_0000 + 32'(idx * 8);
    testVal   = tv;
    go        = 1'b1;
    expLoad   = ((op == 5'd8) || (op == 5'd9)) && expectHit(cc, tv);
    expLink   = (op == 5'd9);
    @(negedge clk);
    go = 1'b0;
    check(pcLoad == expLoad, "R3 R4 R5 R6 R7 pcLoad", 32'(pcLoad), 32'(expLoad));
    check(taken == pcLoad, "R11 taken", 32'(taken), 32'(pcLoad));
    check(linkWe == expLink, "R9 R10 linkWe", 32'(linkWe), 32'(expLink));
    if (expLoad)
      check(pcNew == 32'h1000_0000 + 32'(idx * 8), "R8 pcNew", pcNew,
            32'h1000_0000 + 32'(idx * 8));
    if (expLink) begin
      check(linkIdx == ra, "R9 linkIdx", 32'(linkIdx), 32'(ra));
      check(linkVal == 32'h0000_4000 + 32'(idx * 4), "R9 linkVal", linkVal,
            32'h0000_4000 + 32'(idx * 4));
    end
    @(negedge clk);
    check(!pcLoad && !taken && !linkWe, "R2 idle",
          {29'd0, pcLoad, taken, linkWe}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset, even with go asserted
    go    = 1'b1;
    instr = {5'd9, 5'd3, 5'd3, 5'd0, 9'd0, 3'd1};
    @(negedge clk);
    check(!pcLoad && !taken && !linkWe, "R1 in reset",
          {29'd0, pcLoad, taken, linkWe}, 32'd0);
    go   = 1'b0;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!pcLoad && !taken && !linkWe, "R1 after reset",
          {29'd0, pcLoad, taken, linkWe}, 32'd0);

    for (int op = 0; op < 32; op++) begin
      for (int cc = 0; cc < 8; cc++) begin
        for (int k = 0; k < 5; k++) begin
          runCase(5'(op), 3'(cc), pickTest(k), idx);
          idx++;
        end
      end
    end

    // R2: back-to-back starts, each result one clock after its start
    @(negedge clk);
    instr     = {5'd8, 5'd1, 5'd1, 5'd2, 9'd0, 3'd1};
    targetVal = 32'hAAAA_0000;
    go        = 1'b1;
    @(negedge clk);
    check(pcLoad && pcNew == 32'hAAAA_0000, "R2 first of pair", pcNew, 32'hAAAA_0000);
    instr     = {5'd8, 5'd1, 5'd1, 5'd2, 9'd0, 3'd0};
    targetVal = 32'hBBBB_0000;
    @(negedge clk);
    go = 1'b0;
    check(!pcLoad, "R2 second of pair", 32'(pcLoad), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule